// File: doc/BRIEF.md
# Multi-Port Probe Trigger Comparator

This block watches a set of equally wide probe buses and raises a single trigger flag when a programmed condition holds on them. Each probe port has its own comparator. The comparator can test the probe against a reference value with a relational operator. It can also match a per-bit pattern in which every bit is a fixed level, a don't-care, a rising or falling edge, any edge, or no change. Edges are judged against the probe value seen one clock earlier.

The per-port results are merged by a run-time choice of global AND or global OR into one flag. That flag is registered, so it always lags the probe inputs by exactly one clock. A small write-only register port loads every comparator's operator, signedness, enable and pattern planes, and the global merge mode. A debug fabric instantiates the block next to the logic under observation and uses the flag to start or qualify a capture.

Top module: `probe_match_trigger`

## Requirements
- R1: While reset is asserted and directly after it, `trig_o` is 0, every comparator is disabled, the merge mode is AND, every pattern plane is zero and the stored previous probe value is zero.
- R2: `trig_o` is registered: the value computed from the probe inputs present before a rising clock edge appears on `trig_o` after that edge and holds for one cycle.
- R3: Each pattern bit is coded by three planes (edge at field 3, mask at field 2, value at field 1). With edge=0: mask=0 requires the probe bit to equal the value bit, and mask=1 makes the bit a don't-care.
- R4: With edge=1 the bit is judged against the previous-cycle probe bit: mask=0,value=1 is a rising edge; mask=0,value=0 is a falling edge; mask=1,value=1 is either edge; mask=1,value=0 is no transition.
- R5: Operator code 0 (equal) is true when every pattern bit matches; code 1 (not equal) is its inverse.
- R6: Operator codes 2 (less), 3 (less or equal), 4 (greater) and 5 (greater or equal) compare the whole probe with the value plane and ignore the mask and edge planes. The probe and value are read as unsigned when the signed flag (control bit 3) is 0, and as two's complement when it is 1.
- R7: Operator codes 6 and 7 are reserved and make that comparator's result false.
- R8: Global mode bit 0 selects OR (1) or AND (0) over enabled comparators (control bit 4). A disabled comparator counts as true under AND and false under OR. With none enabled, AND yields 1 and OR yields 0.
- R9: The write address is {global, port[log2 ports], field[2]}. With global=1, data bit 0 sets the merge mode. With global=0, field 0 holds the operator in bits 2:0 plus the signed and enable flags. A write changes the result computed from the next cycle's probe inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (5) | Configuration register address |
| cfg_wdata | input | CFG_DW (8) | Configuration write data |
| probe_i | input | NUM_PORTS*PROBE_W (32) | Probe buses, port 0 in the low bits |
| trig_o | output | 1 | Registered trigger flag |

## Verification
The hardest situations to reach are the transition codes. They depend on the relation between two consecutive probe samples, and configuration write cycles also advance the stored previous value. The stimulus therefore holds the probes steady across every configuration write. It then issues back-to-back probe steps chosen so that one bit rises while another falls, a bit toggles or stays put, and the same value repeats. A reference model tracks the previous sample in lockstep with the design. Signed and unsigned magnitude cases use values with the top bit set, so the two readings disagree.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    OP_EQ = 3'd0,
    OP_NE = 3'd1,
    OP_LT = 3'd2,
    OP_LE = 3'd3,
    OP_GT = 3'd4,
    OP_GE = 3'd5
  } cmp_op_e;

  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_VAL  = 2'd1;
  localparam logic [1:0] FLD_MSK  = 2'd2;
  localparam logic [1:0] FLD_EDG  = 2'd3;

  localparam int CTL_SGN_BIT = 3;
  localparam int CTL_EN_BIT  = 4;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 8,
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [NP-1:0]   en_v,
  output logic [NP-1:0]   sgn_v,
  output logic [NP*3-1:0] op_v,
  output logic [NP*PW-1:0] val_v,
  output logic [NP*PW-1:0] msk_v,
  output logic [NP*PW-1:0] edg_v,
  output logic            or_mode
);
  localparam int PSEL_W = $clog2(NP);

  logic glob_wr;
  logic or_mode_d, or_mode_q;

  assign glob_wr = we && addr[AW-1];

  always_comb begin
    or_mode_d = or_mode_q;
    if (glob_wr) or_mode_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) or_mode_q <= 1'b0;
    else        or_mode_q <= or_mode_d;
  end

  assign or_mode = or_mode_q;

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic          sel;
    logic [1:0]    fld;
    logic          en_d, en_q, sgn_d, sgn_q;
    logic [2:0]    op_d, op_q;
    logic [PW-1:0] val_d, val_q, msk_d, msk_q, edg_d, edg_q;

    assign sel = we && !addr[AW-1] && (addr[AW-2:2] == PSEL_W'(p));
    assign fld = addr[1:0];

    always_comb begin
      en_d  = en_q;
      sgn_d = sgn_q;
      op_d  = op_q;
      val_d = val_q;
      msk_d = msk_q;
      edg_d = edg_q;
      if (sel) begin
        unique case (fld)
          FLD_CTRL: begin
            op_d  = wdata[2:0];
            sgn_d = wdata[CTL_SGN_BIT];
            en_d  = wdata[CTL_EN_BIT];
          end
          FLD_VAL: val_d = wdata[PW-1:0];
          FLD_MSK: msk_d = wdata[PW-1:0];
          FLD_EDG: edg_d = wdata[PW-1:0];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        sgn_q <= 1'b0;
        op_q  <= 3'd0;
        val_q <= '0;
        msk_q <= '0;
        edg_q <= '0;
      end else begin
        en_q  <= en_d;
        sgn_q <= sgn_d;
        op_q  <= op_d;
        val_q <= val_d;
        msk_q <= msk_d;
        edg_q <= edg_d;
      end
    end

    assign en_v[p]            = en_q;
    assign sgn_v[p]           = sgn_q;
    assign op_v[3*p +: 3]     = op_q;
    assign val_v[PW*p +: PW]  = val_q;
    assign msk_v[PW*p +: PW]  = msk_q;
    assign edg_v[PW*p +: PW]  = edg_q;
  end
endmodule

// File: rtl/trig_port_cmp.sv
module trig_port_cmp
  import trig_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic [PW-1:0] cur_i,
  input  logic [PW-1:0] prev_i,
  input  logic [PW-1:0] val_i,
  input  logic [PW-1:0] msk_i,
  input  logic [PW-1:0] edg_i,
  input  logic [2:0]    op_i,
  input  logic          sgn_i,
  output logic          hit_o
);
  logic [PW-1:0] bit_ok;
  logic          pat_eq, same, below;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      unique case ({edg_i[i], msk_i[i]})
        2'b00: bit_ok[i] = (cur_i[i] == val_i[i]);
        2'b01: bit_ok[i] = 1'b1;
        2'b10: bit_ok[i] = val_i[i] ? (cur_i[i] & ~prev_i[i]) : (~cur_i[i] & prev_i[i]);
        default: bit_ok[i] = val_i[i] ? (cur_i[i] ^ prev_i[i]) : ~(cur_i[i] ^ prev_i[i]);
      endcase
    end
  end

  assign pat_eq = &bit_ok;
  assign same   = (cur_i == val_i);
  assign below  = sgn_i ? ($signed(cur_i) < $signed(val_i)) : (cur_i < val_i);

  always_comb begin
    unique case (cmp_op_e'(op_i))
      OP_EQ:   hit_o = pat_eq;
      OP_NE:   hit_o = ~pat_eq;
      OP_LT:   hit_o = below;
      OP_LE:   hit_o = below | same;
      OP_GT:   hit_o = ~(below | same);
      OP_GE:   hit_o = ~below;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/probe_match_trigger.sv
module probe_match_trigger
  import trig_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PROBE_W   = 8,
  localparam int PSEL_W   = $clog2(NUM_PORTS),
  localparam int CFG_AW   = PSEL_W + 3,
  localparam int CFG_DW   = (PROBE_W < 5) ? 5 : PROBE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [CFG_DW-1:0]            cfg_wdata,
  input  logic [NUM_PORTS*PROBE_W-1:0] probe_i,
  output logic                         trig_o
);
  localparam int NP = NUM_PORTS;
  localparam int PW = PROBE_W;

  logic [1:0]      rst_sync_q;
  logic            rst_n_s;
  logic [NP-1:0]   en_v, sgn_v, hit_v;
  logic [NP*3-1:0] op_v;
  logic [NP*PW-1:0] val_v, msk_v, edg_v;
  logic [NP*PW-1:0] hist_d, hist_q;
  logic            or_mode;
  logic            and_res, or_res, trig_d, trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  trig_cfg_regs #(.NP(NP), .PW(PW), .AW(CFG_AW), .DW(CFG_DW)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .en_v    (en_v),
    .sgn_v   (sgn_v),
    .op_v    (op_v),
    .val_v   (val_v),
    .msk_v   (msk_v),
    .edg_v   (edg_v),
    .or_mode (or_mode)
  );

  for (genvar p = 0; p < NP; p++) begin : g_cmp
    trig_port_cmp #(.PW(PW)) cmp_i (
      .cur_i  (probe_i[PW*p +: PW]),
      .prev_i (hist_q[PW*p +: PW]),
      .val_i  (val_v[PW*p +: PW]),
      .msk_i  (msk_v[PW*p +: PW]),
      .edg_i  (edg_v[PW*p +: PW]),
      .op_i   (op_v[3*p +: 3]),
      .sgn_i  (sgn_v[p]),
      .hit_o  (hit_v[p])
    );
  end

  assign and_res = &(hit_v | ~en_v);
  assign or_res  = |(hit_v & en_v);

  always_comb begin
    hist_d = probe_i;
    trig_d = or_mode ? or_res : and_res;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hist_q <= '0;
      trig_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      trig_q <= trig_d;
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/probe_match_trigger_chk.sv
module probe_match_trigger_chk #(
  parameter int NP = 4,
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glob_wr,
  input logic            wbit0,
  input logic [NP*PW-1:0] probe_i,
  input logic [NP*PW-1:0] hist_q,
  input logic [NP-1:0]   en_v,
  input logic [NP-1:0]   hit_v,
  input logic [NP*3-1:0] op_v,
  input logic            or_mode,
  input logic            trig_o
);
  logic started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  // R4
  hist_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (hist_q == $past(probe_i)));

  // R8
  or_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(or_mode && (en_v == '0))) |-> !trig_o);

  // R8
  and_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(!or_mode && (en_v == '0))) |-> trig_o);

  // R9
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(glob_wr)) |-> (or_mode == $past(wbit0)));

  for (genvar p = 0; p < NP; p++) begin : g_rsv
    // R7
    rsv_op_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_v[3*p +: 3] > 3'd5) |-> !hit_v[p]);
  end
endmodule

bind probe_match_trigger probe_match_trigger_chk #(.NP(NUM_PORTS), .PW(PROBE_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .glob_wr (cfg_we && cfg_addr[CFG_AW-1]),
  .wbit0   (cfg_wdata[0]),
  .probe_i (probe_i),
  .hist_q  (hist_q),
  .en_v    (en_v),
  .hit_v   (hit_v),
  .op_v    (op_v),
  .or_mode (or_mode),
  .trig_o  (trig_o)
);

// File: tb/probe_match_trigger_tb_top.sv
module probe_match_trigger_tb_top;
  localparam int CLK_P = 10;
  localparam int NP = 4;
  localparam int PW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [31:0] probe_i;
  logic        trig_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  // reference model state
  bit         m_or;
  bit         m_en [NP];
  bit         m_sg [NP];
  logic [2:0] m_op [NP];
  logic [7:0] m_val[NP];
  logic [7:0] m_msk[NP];
  logic [7:0] m_edg[NP];
  logic [31:0] m_prev;

  always #(CLK_P/2) clk = ~clk;

  probe_match_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .probe_i(probe_i), .trig_o(trig_o)
  );

  function automatic bit bit_match(logic [2:0] code, logic c, logic pv);
    // code = {edge, mask, value}
    case (code)
      3'b000: return c == 1'b0;
      3'b001: return c == 1'b1;
      3'b010, 3'b011: return 1'b1;
      3'b101: return (pv == 1'b0) && (c == 1'b1);
      3'b100: return (pv == 1'b1) && (c == 1'b0);
      3'b111: return pv != c;
      default: return pv == c;
    endcase
  endfunction

  function automatic bit port_hit(int p, logic [7:0] c, logic [7:0] pv);
    bit all_ok = 1'b1;
    int ci, ri;
    for (int b = 0; b < PW; b++)
      if (!bit_match({m_edg[p][b], m_msk[p][b], m_val[p][b]}, c[b], pv[b])) all_ok = 1'b0;
    ci = m_sg[p] ? int'($signed(c)) : int'(c);
    ri = m_sg[p] ? int'($signed(m_val[p])) : int'(m_val[p]);
    case (m_op[p])
      3'd0: return all_ok;
      3'd1: return !all_ok;
      3'd2: return ci < ri;
      3'd3: return ci <= ri;
      3'd4: return ci > ri;
      3'd5: return ci >= ri;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit model_trig(logic [31:0] cur);
    bit acc = !m_or;
    for (int p = 0; p < NP; p++) begin
      if (m_en[p]) begin
        if (m_or) acc = acc | port_hit(p, cur[8*p +: 8], m_prev[8*p +: 8]);
        else      acc = acc & port_hit(p, cur[8*p +: 8], m_prev[8*p +: 8]);
      end
    end
    return acc;
  endfunction

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a[4]) m_or = d[0];
    else begin
      case (a[1:0])
        2'd0: begin m_op[a[3:2]] = d[2:0]; m_sg[a[3:2]] = d[3]; m_en[a[3:2]] = d[4]; end
        2'd1: m_val[a[3:2]] = d;
        2'd2: m_msk[a[3:2]] = d;
        default: m_edg[a[3:2]] = d;
      endcase
    end
    m_prev = probe_i;
  endtask

  task automatic cfg_port(logic [1:0] p, bit en, bit sg, logic [2:0] op,
                          logic [7:0] v, logic [7:0] m, logic [7:0] e);
    wr({1'b0, p, 2'd1}, v);
    wr({1'b0, p, 2'd2}, m);
    wr({1'b0, p, 2'd3}, e);
    wr({1'b0, p, 2'd0}, {3'b000, en, sg, op});
  endtask

  // driver: one probe step, expected result pushed to the scoreboard
  task automatic step(logic [31:0] v, string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    probe_i = v;
    exp_q.push_back(model_trig(v));
    tag_q.push_back(tag);
    m_prev = v;
  endtask

  // monitor: result of the step appears one edge later (R2)
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (trig_o !== e) begin
          errors++;
          $display("FAIL %s: trig_o actual=%0b expected=%0b", t, trig_o, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; probe_i = '0;
    m_or = 1'b0; m_prev = '0;
    for (int p = 0; p < NP; p++) begin
      m_en[p] = 0; m_sg[p] = 0; m_op[p] = 0; m_val[p] = 0; m_msk[p] = 0; m_edg[p] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (trig_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: trig_o actual=%0b expected=0", trig_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R8: defaults are AND mode with every port off -> 1
    step(32'h0, "R1 R8 default AND idle");
    // R9 R8: OR mode with none enabled -> 0
    wr(5'b10000, 8'h01);
    step(32'h0, "R9 R8 OR idle");

    // R3 R5: port0 equal, upper nibble A, lower nibble don't care
    cfg_port(2'd0, 1, 0, 3'd0, 8'hA5, 8'h0F, 8'h00);
    step(32'h0000_00A0, "R3 R5 level match dc");
    step(32'h0000_00B5, "R3 R5 level miss");
    step(32'h0000_00AF, "R3 R2 level match");
    // R5 not equal
    wr(5'b00000, 8'h11);
    step(32'h0000_00AF, "R5 NE on match");
    step(32'h0000_0035, "R5 NE on miss");

    // R4: bit0 rise, bit1 fall, rest dc
    cfg_port(2'd0, 1, 0, 3'd0, 8'h01, 8'hFC, 8'h03);
    step(32'h0000_0002, "R4 setup");
    step(32'h0000_0001, "R4 rise+fall");
    step(32'h0000_0001, "R4 no edge");
    step(32'h0000_0003, "R4 rise only");
    // R4: bit2 either edge, bit3 no transition
    cfg_port(2'd0, 1, 0, 3'd0, 8'h04, 8'hFF, 8'h0C);
    step(32'h0000_0000, "R4 setup2");
    step(32'h0000_0004, "R4 either rise");
    step(32'h0000_0000, "R4 either fall");
    step(32'h0000_0000, "R4 either none");
    step(32'h0000_000C, "R4 bit3 changed");

    // R6: port1 magnitude, port0 off
    wr(5'b00000, 8'h00);
    cfg_port(2'd1, 1, 0, 3'd2, 8'h10, 8'hFF, 8'hFF);
    step(32'h0000_F000, "R6 LT unsigned big");
    step(32'h0000_0F00, "R6 LT unsigned small mask ignored");
    wr(5'b00100, 8'h1A);
    step(32'h0000_F000, "R6 LT signed negative");
    wr(5'b00100, 8'h1B);
    step(32'h0000_1000, "R6 LE equal");
    wr(5'b00100, 8'h1C);
    step(32'h0000_1000, "R6 GT equal");
    step(32'h0000_7F00, "R6 GT positive");
    wr(5'b00100, 8'h15);
    step(32'h0000_8000, "R6 GE unsigned big");
    step(32'h0000_1000, "R6 GE equal");

    // R7 reserved opcodes
    wr(5'b00100, 8'h16);
    step(32'h0000_1000, "R7 op6 OR");
    wr(5'b00100, 8'h17);
    wr(5'b10000, 8'h00);
    step(32'h0000_1000, "R7 op7 AND");

    // R8 AND over two ports, disabled ports ignored
    cfg_port(2'd1, 1, 0, 3'd0, 8'h33, 8'h00, 8'h00);
    cfg_port(2'd2, 1, 0, 3'd0, 8'h44, 8'h00, 8'h00);
    step(32'h0044_3300, "R8 AND both");
    step(32'h0045_3300, "R8 AND one");
    wr(5'b10000, 8'h01);
    step(32'h0045_3300, "R8 OR one");
    step(32'h0045_3400, "R8 OR none");
    // R9 ctrl write disables port2, effective on next step
    wr(5'b01000, 8'h00);
    wr(5'b10000, 8'h00);
    step(32'h0099_3300, "R9 R8 AND port2 off");

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule